// File: doc/BRIEF.md
# Function-Unit Dependency Matrix Scoreboard

This block keeps the ordering and hazard state between a set of function units, load and store units included. It holds three square matrices of one-bit latches, one row and one column per unit. The read-after-write matrix records which producers must finish before a unit may read its operands. The write-after-write matrix records which earlier writers must finish before a unit may write back. The age matrix records every unit that was already busy when a unit was issued, so that results commit in program order.

From this state the block produces three registered vectors. `go_read_o` lets a unit start executing as soon as its producers are clear. `go_write_o` lets a finished unit write back once no write-after-write latch is set and it is not holding write-prevention. `commit_ready_o` adds the age condition, so only the oldest outstanding unit is told it may commit. A unit that has begun but may not commit keeps its result buffered. A unit holds write-prevention while an exception or a mispredicted speculation is still possible. A go-die kill vector removes a wrongly speculated unit and every latch that points at it. A commit strobe retires a unit in the same way.

Top module: `fu_dep_scoreboard`

## Requirements
- R1: Synchronous reset, active high, clears every latch and marks every unit idle. In the cycle after a reset edge all three output vectors read zero.
- R2: An issue (`issue_valid_in` with binary unit number `issue_unit_in`) to an idle unit marks it busy. It stores `issue_raw_in` as its read dependencies and `issue_waw_in` as its write dependencies. Bit j of each vector names unit j.
- R3: `go_read_o[i]` is high while unit i is busy and none of its stored read dependencies remains set.
- R4: `go_write_o[i]` is high while unit i is busy, `done_in[i]` is high, no write dependency of unit i remains set and `hold_in[i]` is low.
- R5: A high `hold_in[i]` forces `go_write_o[i]` and `commit_ready_o[i]` low for the output cycle that follows.
- R6: `commit_ready_o[i]` equals the `go_write_o[i]` condition with one extra term: no unit that was busy when unit i issued is still busy. At most one bit is ever high.
- R7: A high `kill_in[i]` returns unit i to idle. It clears its row and its column in every matrix, and all three of its output bits read zero in the next output cycle.
- R8: A high `commit_in[i]` retires unit i in the same way as a kill. Units waiting on it see the latch cleared in the next output cycle.
- R9: An issue to a unit that is busy, or that is killed or committed in the same cycle, is ignored. An issue to that unit on the following cycle is accepted.
- R10: At issue, a dependency bit is kept only for a unit that is busy and not being released in that cycle. A bit naming an idle unit or the issuing unit itself has no effect.
- R11: Each output reflects the state and the `done_in`/`hold_in` values of the previous clock edge, one register stage after the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid_in | input | 1 | Issue request this cycle |
| issue_unit_in | input | $clog2(NUM_FU) | Binary number of the unit being issued |
| issue_raw_in | input | NUM_FU | Producer units whose results the issued operation reads |
| issue_waw_in | input | NUM_FU | Units whose pending write must precede the issued one |
| done_in | input | NUM_FU | Unit has its result buffered |
| hold_in | input | NUM_FU | Write-prevention hold per unit |
| kill_in | input | NUM_FU | Go-die: discard the unit and its state |
| commit_in | input | NUM_FU | Commit strobe: unit retires |
| go_read_o | output | NUM_FU | Operand read permission |
| go_write_o | output | NUM_FU | Writeback permission |
| commit_ready_o | output | NUM_FU | Writeback permitted and unit is the oldest outstanding |

## Verification
The bench targets the cycle in which a producer is released while a consumer is issued against it. A design that failed to mask released units would latch a dependency that nothing ever clears, and that consumer would never read. It issues to units that are busy or being released in the same cycle; a design that accepts those would overwrite live dependency rows. It keeps several finished units waiting behind an older one. A broken age matrix would then raise more than one commit-ready bit or let a younger unit commit first. Kills in the middle of chains check that dependants are freed instead of left stuck behind a dead unit.

// File: rtl/fu_sb_pkg.sv
package fu_sb_pkg;
  localparam int SB_UNITS_DEFAULT = 8;

  // matrix kinds held by the scoreboard
  typedef enum int {
    MX_RAW = 0,
    MX_WAW = 1,
    MX_AGE = 2
  } mx_kind_e;

  localparam int MX_COUNT = 3;
endpackage

// File: rtl/fu_busy_track.sv
module fu_busy_track #(
  parameter int NUM_FU = 8,
  parameter int IW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [IW-1:0]     issue_unit,
  input  logic [NUM_FU-1:0] release_vec,
  output logic [NUM_FU-1:0] busy_q,
  output logic [NUM_FU-1:0] busy_d,
  output logic [NUM_FU-1:0] accept_mask
);

  always_comb begin
    accept_mask = '0;
    if (issue_valid && (int'(issue_unit) < NUM_FU)) begin
      if (!busy_q[issue_unit] && !release_vec[issue_unit])
        accept_mask[issue_unit] = 1'b1;
    end
  end

  assign busy_d = (busy_q & ~release_vec) | accept_mask;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= '0;
    else     busy_q <= busy_d;
  end

endmodule

// File: rtl/fu_dep_matrix.sv
module fu_dep_matrix #(
  parameter int NUM_FU = 8,
  parameter int IW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_row,
  input  logic [NUM_FU-1:0] wr_vec,
  input  logic [NUM_FU-1:0] clr_col,
  input  logic [NUM_FU-1:0] clr_row,
  output logic [NUM_FU-1:0] row_pending_d
);

  for (genvar r = 0; r < NUM_FU; r++) begin : g_row
    logic [NUM_FU-1:0] cell_q;
    logic [NUM_FU-1:0] cell_d;

    always_comb begin
      if (wr_en && (int'(wr_row) == r))
        cell_d = wr_vec;
      else if (clr_row[r])
        cell_d = '0;
      else
        cell_d = cell_q & ~clr_col;
    end

    always_ff @(posedge clk) begin
      if (rst) cell_q <= '0;
      else     cell_q <= cell_d;
    end

    assign row_pending_d[r] = |cell_d;
  end

endmodule

// File: rtl/fu_dep_scoreboard.sv
module fu_dep_scoreboard #(
  parameter int NUM_FU = fu_sb_pkg::SB_UNITS_DEFAULT,
  localparam int IW    = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid_in,
  input  logic [IW-1:0]     issue_unit_in,
  input  logic [NUM_FU-1:0] issue_raw_in,
  input  logic [NUM_FU-1:0] issue_waw_in,
  input  logic [NUM_FU-1:0] done_in,
  input  logic [NUM_FU-1:0] hold_in,
  input  logic [NUM_FU-1:0] kill_in,
  input  logic [NUM_FU-1:0] commit_in,
  output logic [NUM_FU-1:0] go_read_o,
  output logic [NUM_FU-1:0] go_write_o,
  output logic [NUM_FU-1:0] commit_ready_o
);
  import fu_sb_pkg::*;

  logic [NUM_FU-1:0] release_vec;
  logic [NUM_FU-1:0] busy_q, busy_d, accept_mask;
  logic [NUM_FU-1:0] dep_base;
  logic [NUM_FU-1:0] set_vec [MX_COUNT];
  logic [NUM_FU-1:0] pend_d  [MX_COUNT];
  logic [NUM_FU-1:0] go_read_d, go_write_d, commit_ready_d;

  assign release_vec = kill_in | commit_in;

  fu_busy_track #(.NUM_FU(NUM_FU), .IW(IW)) u_busy (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid_in),
    .issue_unit  (issue_unit_in),
    .release_vec (release_vec),
    .busy_q      (busy_q),
    .busy_d      (busy_d),
    .accept_mask (accept_mask)
  );

  // only units that stay busy across this edge can be waited on
  assign dep_base        = busy_q & ~release_vec;
  assign set_vec[MX_RAW] = issue_raw_in & dep_base;
  assign set_vec[MX_WAW] = issue_waw_in & dep_base;
  assign set_vec[MX_AGE] = dep_base;

  for (genvar k = 0; k < MX_COUNT; k++) begin : g_mx
    fu_dep_matrix #(.NUM_FU(NUM_FU), .IW(IW)) u_mx (
      .clk           (clk),
      .rst           (rst),
      .wr_en         (|accept_mask),
      .wr_row        (issue_unit_in),
      .wr_vec        (set_vec[k]),
      .clr_col       (release_vec),
      .clr_row       (release_vec),
      .row_pending_d (pend_d[k])
    );
  end

  assign go_read_d      = busy_d & ~pend_d[MX_RAW];
  assign go_write_d     = busy_d & done_in & ~pend_d[MX_WAW] & ~hold_in;
  assign commit_ready_d = go_write_d & ~pend_d[MX_AGE];

  always_ff @(posedge clk) begin
    if (rst) begin
      go_read_o      <= '0;
      go_write_o     <= '0;
      commit_ready_o <= '0;
    end else begin
      go_read_o      <= go_read_d;
      go_write_o     <= go_write_d;
      commit_ready_o <= commit_ready_d;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (go_read_o == '0 && go_write_o == '0 && commit_ready_o == '0));

  // R5
  hold_block_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_in != '0) |=> ((go_write_o | commit_ready_o) & $past(hold_in)) == '0);

  // R6
  single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(commit_ready_o));

  // R7
  kill_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (kill_in != '0) |=>
      ((go_read_o | go_write_o | commit_ready_o) & $past(kill_in)) == '0);

  // R8
  commit_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_in != '0) |=>
      ((go_read_o | go_write_o | commit_ready_o) & $past(commit_in)) == '0);

endmodule

// File: tb/fu_dep_scoreboard_bench.sv
module fu_dep_scoreboard_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         issue_valid_in = 1'b0;
  logic [2:0]   issue_unit_in = '0;
  logic [N-1:0] issue_raw_in = '0, issue_waw_in = '0;
  logic [N-1:0] done_in = '0, hold_in = '0, kill_in = '0, commit_in = '0;
  logic [N-1:0] go_read_o, go_write_o, commit_ready_o;

  int    checks = 0;
  int    failures = 0;
  string phase = "R1 reset";
  bit    finished = 0;

  always #2 clk = ~clk;

  fu_dep_scoreboard u_fu_dep_scoreboard (
    .clk(clk), .rst(rst),
    .issue_valid_in(issue_valid_in), .issue_unit_in(issue_unit_in),
    .issue_raw_in(issue_raw_in), .issue_waw_in(issue_waw_in),
    .done_in(done_in), .hold_in(hold_in), .kill_in(kill_in),
    .commit_in(commit_in),
    .go_read_o(go_read_o), .go_write_o(go_write_o),
    .commit_ready_o(commit_ready_o)
  );

  // behavioural reference: busy flags, dependency lists, issue sequence numbers
  bit           m_busy [N];
  logic [N-1:0] m_raw  [N];
  logic [N-1:0] m_waw  [N];
  int           m_seq  [N];
  int           seq_ctr = 0;
  logic [N-1:0] exp_gr = '0, exp_gw = '0, exp_cr = '0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_busy[i] = 0; m_raw[i] = '0; m_waw[i] = '0; m_seq[i] = 0;
      end
      exp_gr = '0; exp_gw = '0; exp_cr = '0;
    end else begin
      logic [N-1:0] rel, live;
      int u;
      bit acc;
      rel = kill_in | commit_in;
      u = int'(issue_unit_in);
      acc = issue_valid_in && !m_busy[u] && !rel[u];
      live = '0;
      for (int j = 0; j < N; j++) live[j] = m_busy[j] && !rel[j];
      for (int j = 0; j < N; j++) begin
        if (rel[j]) begin
          m_busy[j] = 0; m_raw[j] = '0; m_waw[j] = '0;
          for (int i = 0; i < N; i++) begin
            m_raw[i][j] = 1'b0; m_waw[i][j] = 1'b0;
          end
        end
      end
      if (acc) begin
        m_busy[u] = 1;
        m_raw[u]  = issue_raw_in & live;
        m_waw[u]  = issue_waw_in & live;
        m_seq[u]  = seq_ctr;
        seq_ctr++;
      end
      for (int i = 0; i < N; i++) begin
        bit oldest;
        oldest = 1;
        for (int j = 0; j < N; j++)
          if (m_busy[j] && j != i && m_seq[j] < m_seq[i]) oldest = 0;
        exp_gr[i] = m_busy[i] && (m_raw[i] == '0);
        exp_gw[i] = m_busy[i] && done_in[i] && (m_waw[i] == '0) && !hold_in[i];
        exp_cr[i] = exp_gw[i] && oldest;
      end
    end
  end

  task automatic check(string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", phase, what, act, exp);
    end
  endtask

  // R11: outputs compared every cycle, one edge after the stimulus
  always @(negedge clk) begin
    if (!finished) begin
      check("go_read", go_read_o, exp_gr);
      check("go_write", go_write_o, exp_gw);
      check("commit_ready", commit_ready_o, exp_cr);
    end
  end

  task automatic cyc();
    @(negedge clk);
    issue_valid_in = 1'b0; kill_in = '0; commit_in = '0;
    issue_raw_in = '0; issue_waw_in = '0;
  endtask

  task automatic issue(int u, logic [N-1:0] raw, logic [N-1:0] waw);
    issue_valid_in = 1'b1; issue_unit_in = u[2:0];
    issue_raw_in = raw; issue_waw_in = waw;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    phase = "R1 after reset";
    cyc();
    phase = "R2 issue idle unit";
    issue(0, '0, '0); cyc();
    issue(1, 8'b0000_0001, '0); cyc();
    phase = "R10 dep on idle or self";
    issue(2, 8'b0010_0100, '0); cyc();
    phase = "R4 write gating";
    issue(3, '0, 8'b0000_0001); done_in = 8'b0000_1101; cyc();
    cyc();
    phase = "R5 hold";
    hold_in = 8'b0000_0001; cyc();
    cyc();
    hold_in = '0;
    phase = "R6 oldest commit";
    cyc(); cyc();
    phase = "R8 commit frees";
    commit_in = 8'b0000_0001; cyc();
    phase = "R3 read after release";
    cyc();
    phase = "R9 issue to busy";
    issue(1, 8'b0000_1000, 8'b0000_1000); cyc();
    commit_in = 8'b0000_0100; issue(2, 8'b0000_1000, '0); cyc();
    issue(2, 8'b0000_1000, '0); cyc();
    phase = "R7 kill frees";
    kill_in = 8'b0000_1000; cyc();
    cyc();
    phase = "R10 issue vs same-cycle release";
    commit_in = 8'b0000_0010; issue(4, 8'b0000_0010, 8'b0000_0010); cyc();
    cyc();
    kill_in = 8'b1111_1111; done_in = '0; cyc();
    phase = "R6 ordering random mix";
    for (int t = 0; t < 600; t++) begin
      if ($urandom_range(0, 2) != 0)
        issue($urandom_range(0, N-1), N'($urandom), N'($urandom));
      if ($urandom_range(0, 5) == 0) commit_in = N'(1 << $urandom_range(0, N-1));
      if ($urandom_range(0, 11) == 0) kill_in = N'($urandom) & N'($urandom);
      done_in = N'($urandom) | N'($urandom);
      hold_in = N'($urandom) & N'($urandom) & N'($urandom);
      if ($urandom_range(0, 3) == 0) commit_in = commit_in | (go_write_o & commit_ready_o);
      cyc();
    end
    phase = "R1 reset again";
    rst = 1'b1; cyc(); cyc();
    rst = 1'b0; cyc();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

endmodule